// File: doc/BRIEF.md
# Coalescing Two-Level Interrupt Controller

This block gathers event pulses from a DMA flow handler and from several other on-chip sources and presents one level-sensitive interrupt line to the host. Events land in two sticky status registers. The flow-handler register keeps the individual receive, transmit, error and high-priority receive flags. The main register keeps the remaining sources, plus three summary bits that each stand for a group of flow-handler flags. The host clears any flag by writing a 1 to its position, and an enable mask decides which main bits may raise the line.

To reduce the interrupt rate, a coalescing timer holds the line back once something is pending. The timer counts microsecond ticks in units of 32 ticks. A coalescing value of zero turns the timer off. A pending high-priority receive flag overrides the timer altogether. All registers are reached through a small word-addressed port: one write strobe, a combinational read, and a 2-bit address.

Top module: `irq_coalesce_ctrl`

## Requirements
- R1: After reset every register (address 0 coalescing, 1 main status, 2 enable mask, 3 flow-handler status) reads zero and `host_irq` is low.
- R2: A pulse on `main_evt` at bit 0, 1, 6, 7 or 25 sets the same bit of the main status, which then holds until a write to address 1 with a 1 at that bit. A 0 in the write data leaves a bit unchanged, and an event arriving in the same cycle as its clear keeps the bit set.
- R3: A pulse on `fh_evt` at bit 0, 1, 16, 17, 30 or 31 sets the same bit of the flow-handler status at address 3. That bit is cleared by writing 1 there, with the same rules as R2.
- R4: Event inputs at every other bit position are ignored, and those status bits always read 0.
- R5: Main bit 31 reads 1 while any of flow-handler bits 16, 17 or 30 is set. Main bit 27 reads 1 while flow-handler bit 0 or 1 is set. Main bit 29 reads 1 while flow-handler bit 31 is set. Writes to address 1 cannot clear these three bits.
- R6: The mask at address 2 is read/write, and `host_irq` is low whenever main status AND mask is zero.
- R7: The coalescing value at address 0 is 8 bits wide, and its upper bits read 0. For a value N > 0, `host_irq` rises after the N*32-th `us_tick`, counting only ticks sampled while masked status is nonzero. It stays low after N*32-1 such ticks.
- R8: With a coalescing value of 0, `host_irq` is high in the first cycle in which masked status is nonzero.
- R9: While flow-handler bit 30 is set and mask bit 31 is set, `host_irq` is high whatever the timer state.
- R10: Once raised, `host_irq` stays high until masked status reaches zero. The timer then restarts from zero for the next pending event, and ticks seen with nothing pending do not count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| main_evt | input | 32 | Event pulses for the direct main status bits |
| fh_evt | input | 32 | Event pulses from the flow handler |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Write data (write-1-to-clear for status registers) |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| host_irq | output | 1 | Interrupt line to the host |

## Verification
The timer assertion assumes that `us_tick` is a single-cycle pulse, and that a rising `host_irq` outside bypass and zero-coalescing mode can only follow a sampled tick. The bench meets this by raising the tick for exactly one cycle at a time, and by holding it low while events or register writes are applied. The write-clear assertion assumes the host never writes to address 1 in the same cycle as an event on that bit. The bench keeps to this everywhere except in one directed collision case, which it checks only at the ports.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int DATA_W = 32;
    localparam int REG_AW = 2;

    typedef enum logic [REG_AW-1:0] {
        SEL_COAL = 2'd0,
        SEL_MAIN = 2'd1,
        SEL_MASK = 2'd2,
        SEL_FH   = 2'd3
    } reg_sel_e;

    // main register bit positions decoded by the host
    localparam int MAIN_RX_SUM = 31;
    localparam int MAIN_HW_ERR = 29;
    localparam int MAIN_TX_SUM = 27;
    localparam int FH_HIPRI    = 30;

    localparam logic [DATA_W-1:0] MAIN_DIRECT_BITS = 32'h0200_00C3;
    localparam logic [DATA_W-1:0] FH_IMPL_BITS     = 32'hC003_0003;

    localparam int NUM_FOLD = 3;
    localparam logic [DATA_W-1:0] FOLD_SRC [NUM_FOLD] = '{
        32'h4003_0000,   // receive group incl. high priority
        32'h8000_0000,   // flow-handler error
        32'h0000_0003    // transmit group
    };
    localparam int FOLD_DST [NUM_FOLD] = '{MAIN_RX_SUM, MAIN_HW_ERR, MAIN_TX_SUM};
endpackage

// File: rtl/irqc_w1c_reg.sv
module irqc_w1c_reg #(
    parameter int                W    = 32,
    parameter logic [W-1:0]      IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         clr_en_i,
    input  logic [W-1:0] clr_bits_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] bits;
    } w1c_state_t;

    w1c_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_en_i) begin
            st_d.bits = st_d.bits & ~clr_bits_i;
        end
        // a new event wins over a clear in the same cycle
        st_d.bits = (st_d.bits | set_i) & IMPL;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o = st_q.bits;
endmodule

// File: rtl/irqc_fold.sv
module irqc_fold
    import irqc_pkg::*;
(
    input  logic [DATA_W-1:0] fh_stat_i,
    output logic [DATA_W-1:0] sum_o
);
    logic [NUM_FOLD-1:0] hit;

    for (genvar g = 0; g < NUM_FOLD; g++) begin : g_fold
        assign hit[g] = |(fh_stat_i & FOLD_SRC[g]);
    end

    always_comb begin
        sum_o = '0;
        for (int g = 0; g < NUM_FOLD; g++) begin
            sum_o[FOLD_DST[g]] = hit[g];
        end
    end
endmodule

// File: rtl/irqc_coalesce.sv
module irqc_coalesce #(
    parameter int COAL_W         = 8,
    parameter int TICKS_PER_UNIT = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              pending_i,
    input  logic              bypass_i,
    input  logic [COAL_W-1:0] coal_i,
    output logic              irq_o
);
    localparam int UNIT_LOG2 = $clog2(TICKS_PER_UNIT);
    localparam int CNT_W     = COAL_W + UNIT_LOG2 + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             expired;
    } coal_state_t;

    coal_state_t      st_d, st_q;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] cnt_inc;

    assign limit   = CNT_W'(coal_i) * CNT_W'(TICKS_PER_UNIT);
    assign cnt_inc = st_q.cnt + CNT_W'(1);

    always_comb begin
        st_d = st_q;
        if (!pending_i) begin
            st_d.cnt     = '0;
            st_d.expired = 1'b0;
        end else if (!st_q.expired && tick_i) begin
            st_d.cnt = cnt_inc;
            if (cnt_inc >= limit) begin
                st_d.expired = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o = pending_i & (st_q.expired | bypass_i | (coal_i == '0));
endmodule

// File: rtl/irq_coalesce_ctrl.sv
module irq_coalesce_ctrl
    import irqc_pkg::*;
#(
    parameter int COAL_W         = 8,
    parameter int TICKS_PER_UNIT = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              us_tick,
    input  logic [DATA_W-1:0] main_evt,
    input  logic [DATA_W-1:0] fh_evt,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              host_irq
);
    typedef struct packed {
        logic [COAL_W-1:0] coal;
        logic [DATA_W-1:0] mask;
    } cfg_t;

    cfg_t              cfg_d, cfg_q;
    reg_sel_e          sel;
    logic [DATA_W-1:0] fh_stat_w;
    logic [DATA_W-1:0] direct_w;
    logic [DATA_W-1:0] fold_w;
    logic [DATA_W-1:0] main_stat_w;
    logic [DATA_W-1:0] mask_w;
    logic [COAL_W-1:0] coal_w;
    logic              pending_w;
    logic              bypass_w;

    assign sel = reg_sel_e'(reg_addr);

    always_comb begin
        cfg_d = cfg_q;
        if (reg_wr && sel == SEL_COAL) cfg_d.coal = reg_wdata[COAL_W-1:0];
        if (reg_wr && sel == SEL_MASK) cfg_d.mask = reg_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign mask_w = cfg_q.mask;
    assign coal_w = cfg_q.coal;

    irqc_w1c_reg #(.W(DATA_W), .IMPL(FH_IMPL_BITS)) u_fh_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (fh_evt),
        .clr_en_i   (reg_wr && sel == SEL_FH),
        .clr_bits_i (reg_wdata),
        .q_o        (fh_stat_w)
    );

    irqc_w1c_reg #(.W(DATA_W), .IMPL(MAIN_DIRECT_BITS)) u_main_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (main_evt),
        .clr_en_i   (reg_wr && sel == SEL_MAIN),
        .clr_bits_i (reg_wdata),
        .q_o        (direct_w)
    );

    irqc_fold u_fold (
        .fh_stat_i (fh_stat_w),
        .sum_o     (fold_w)
    );

    assign main_stat_w = direct_w | fold_w;
    assign pending_w   = |(main_stat_w & mask_w);
    assign bypass_w    = fh_stat_w[FH_HIPRI] & mask_w[MAIN_RX_SUM];

    irqc_coalesce #(.COAL_W(COAL_W), .TICKS_PER_UNIT(TICKS_PER_UNIT)) u_coal (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (us_tick),
        .pending_i (pending_w),
        .bypass_i  (bypass_w),
        .coal_i    (coal_w),
        .irq_o     (host_irq)
    );

    always_comb begin
        case (sel)
            SEL_COAL: reg_rdata = DATA_W'(coal_w);
            SEL_MAIN: reg_rdata = main_stat_w;
            SEL_MASK: reg_rdata = mask_w;
            default:  reg_rdata = fh_stat_w;
        endcase
    end
endmodule

// File: rtl/irq_coalesce_ctrl_sva.sv
module irq_coalesce_ctrl_sva #(
    parameter int COAL_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              us_tick,
    input logic [31:0]       main_evt,
    input logic              reg_wr,
    input logic [1:0]        reg_addr,
    input logic [31:0]       reg_wdata,
    input logic [31:0]       main_stat,
    input logic [31:0]       fh_stat,
    input logic [31:0]       mask,
    input logic [COAL_W-1:0] coal,
    input logic              host_irq
);
    assert_irq_needs_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> (|(main_stat & mask)));

    assert_w1c_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd1 && reg_wdata[0] && !main_evt[0]) |=> !main_stat[0]);

    assert_event_sticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        main_evt[25] |=> main_stat[25]);

    assert_rx_fold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|fh_stat[17:16]) |-> main_stat[31]);

    assert_err_fold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !fh_stat[31] |-> !main_stat[29]);

    assert_bypass_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fh_stat[30] && mask[31]) |-> host_irq);

    assert_zero_coal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (coal == '0 && (|(main_stat & mask))) |-> host_irq);

    assert_timer_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(host_irq) && coal != '0 && !(fh_stat[30] && mask[31])) |-> $past(us_tick));
endmodule

bind irq_coalesce_ctrl irq_coalesce_ctrl_sva #(.COAL_W(COAL_W)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .us_tick   (us_tick),
    .main_evt  (main_evt),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .main_stat (main_stat_w),
    .fh_stat   (fh_stat_w),
    .mask      (mask_w),
    .coal      (coal_w),
    .host_irq  (host_irq)
);

// File: tb/irq_coalesce_ctrl_bench.sv
`timescale 1ns/1ps
module irq_coalesce_ctrl_bench;
    localparam logic [31:0] DIRECT = 32'h0200_00C3;
    localparam logic [31:0] FH_OK  = 32'hC003_0003;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        us_tick = 1'b0;
    logic [31:0] main_evt = '0;
    logic [31:0] fh_evt = '0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        host_irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    irq_coalesce_ctrl u_irq_coalesce_ctrl (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .main_evt(main_evt),
        .fh_evt(fh_evt), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .host_irq(host_irq)
    );

    function automatic logic [31:0] fold(input logic [31:0] fh);
        logic [31:0] r = '0;
        r[31] = fh[30] | fh[17] | fh[16];
        r[29] = fh[31];
        r[27] = fh[1] | fh[0];
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, input string req, input logic [31:0] exp);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic pulse_main(input logic [31:0] v);
        @(negedge clk); main_evt = v;
        @(negedge clk); main_evt = '0;
    endtask

    task automatic pulse_fh(input logic [31:0] v);
        @(negedge clk); fh_evt = v;
        @(negedge clk); fh_evt = '0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); us_tick = 1'b1;
            @(negedge clk); us_tick = 1'b0;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 4; a++) rd(2'(a), "R1 reset read", 32'h0);
        check("R1 irq after reset", 32'(host_irq), 32'h0);

        // R2 / R4 sweep of main event bits, mask closed (R6)
        for (int b = 0; b < 32; b++) begin
            logic [31:0] v = 32'h1 << b;
            pulse_main(v);
            rd(2'd1, "R2 R4 main set", v & DIRECT);
            check("R6 irq masked off", 32'(host_irq), 32'h0);
            wr(2'd1, 32'h0);
            rd(2'd1, "R2 zero write keeps", v & DIRECT);
            wr(2'd1, v);
            rd(2'd1, "R2 w1c clear", 32'h0);
        end

        // R3 / R4 / R5 sweep of flow-handler bits
        for (int b = 0; b < 32; b++) begin
            logic [31:0] v = 32'h1 << b;
            pulse_fh(v);
            rd(2'd3, "R3 R4 fh set", v & FH_OK);
            rd(2'd1, "R5 fold", fold(v & FH_OK));
            wr(2'd1, 32'hFFFF_FFFF);
            rd(2'd1, "R5 summary not host-clearable", fold(v & FH_OK));
            wr(2'd3, v);
            rd(2'd3, "R3 fh w1c", 32'h0);
            rd(2'd1, "R5 summary follows source", 32'h0);
        end

        // R2 set wins over clear
        @(negedge clk);
        main_evt = 32'h1; reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h1;
        @(negedge clk);
        main_evt = '0; reg_wr = 1'b0; reg_wdata = '0;
        rd(2'd1, "R2 event beats clear", 32'h1);
        wr(2'd1, 32'h1);

        // R6 mask register, R7 coalescing width
        wr(2'd2, 32'hA5A5_5A5A);
        rd(2'd2, "R6 mask rw", 32'hA5A5_5A5A);
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, "R7 coal width", 32'h0000_00FF);
        wr(2'd0, 32'h0);

        // R8 immediate mode, R6 gating per bit
        for (int b = 0; b < 32; b++) begin
            logic [31:0] v = 32'h1 << b;
            if ((v & DIRECT) != 0) begin
                wr(2'd2, ~v);
                pulse_main(v);
                check("R6 irq gated by mask", 32'(host_irq), 32'h0);
                wr(2'd2, 32'hFFFF_FFFF);
                check("R8 immediate irq", 32'(host_irq), 32'h1);
                wr(2'd1, v);
                check("R10 irq drops on clear", 32'(host_irq), 32'h0);
            end
        end

        // R7 / R10 coalescing timer for N = 1..3
        wr(2'd2, 32'h0000_0001);
        for (int n = 1; n <= 3; n++) begin
            wr(2'd0, 32'(n));
            ticks(40);
            pulse_main(32'h1);
            ticks(n * 32 - 1);
            check("R7 R10 held before limit", 32'(host_irq), 32'h0);
            ticks(1);
            check("R7 raised at limit", 32'(host_irq), 32'h1);
            ticks(5);
            check("R10 stays raised", 32'(host_irq), 32'h1);
            wr(2'd1, 32'h1);
            check("R10 dropped", 32'(host_irq), 32'h0);
            pulse_main(32'h1);
            ticks(n * 32 - 1);
            check("R10 timer restarted", 32'(host_irq), 32'h0);
            ticks(1);
            check("R7 raised again", 32'(host_irq), 32'h1);
            wr(2'd1, 32'h1);
        end

        // R9 high-priority bypass
        wr(2'd0, 32'hFF);
        wr(2'd2, 32'h8000_0000);
        pulse_fh(32'h0001_0000);
        check("R9 plain rx waits", 32'(host_irq), 32'h0);
        pulse_fh(32'h4000_0000);
        check("R9 bypass", 32'(host_irq), 32'h1);
        wr(2'd3, 32'h4000_0000);
        check("R9 bypass gone, timer holds", 32'(host_irq), 32'h0);
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd1, "R5 all clear", 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule